// File: doc/BRIEF.md
# Instruction Prefix and Length Validator

This block sits beside an instruction fetch path that delivers one byte per valid cycle, together with a start flag on the first byte of each instruction and an end flag on its last byte. The end flag comes from the upstream source, so the block does not decode instruction lengths itself. It counts the bytes of the current instruction and skips over the prefix bytes. It notes whether a bus-lock prefix was present. It then finds the opcode, including the opcode that follows the 0F escape, and finds the addressing byte after it.

For every instruction the block produces exactly one result strobe. The result is one of three kinds. The instruction is legal. Or it has grown past the length ceiling, which raises vector 13. Or it carries the lock prefix but is not a read-modify-write instruction with a memory destination, which raises vector 6. A length fault is reported as soon as the offending byte arrives. Any remaining bytes of a faulted instruction are ignored until the next start flag.

Top module: `insn_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, `res_vld` is 0.
- R2: An instruction of at most 15 bytes that does not carry the lock prefix produces one strobe in the cycle after its end byte, with `res_kind`=0 (legal) and `res_vector`=0.
- R3: The 16th byte of an instruction produces a strobe in the next cycle with `res_kind`=1 and `res_vector`=13, without waiting for the end flag. Repeated prefixes count toward this limit, and a 15-byte instruction is still legal.
- R4: After a fault, no further strobe appears for the same instruction. Its remaining bytes, including its end byte, are ignored.
- R5: A locked instruction is legal when its opcode is whitelisted and its addressing byte has mod (bits 7:6) other than 3. The whitelisted one-byte opcodes are the ALU forms 00/01, 08/09, 10/11, 18/19, 20/21, 28/29 and 30/31, and also 86/87, both with any reg field. The reg field is bits 5:3 of the addressing byte.
- R6: The lock prefix on an opcode outside the whitelist gives `res_kind`=2 and `res_vector`=6 in the cycle after the end byte. Examples are 89, 38 and a lock prefix with no opcode at all.
- R7: The lock prefix also gives the kind 2 / vector 6 result when the addressing byte has mod 3, or when the reg field is outside the set allowed for the opcode. The allowed sets are 0–6 for 80–83, 0–1 for FE/FF and 2–3 for F6/F7.
- R8: After the 0F escape, the opcodes AB, B3 and BB are lockable with any reg field. BA is lockable only with reg 5, 6 or 7. Every other second byte is not lockable.
- R9: When the 16th byte is also the end byte of a locked instruction that is not permitted, the result is the length fault (kind 1, vector 13).
- R10: A start flag in the middle of an instruction abandons it without a strobe. Valid bytes that arrive with no instruction open are ignored.
- R11: The bytes F0 (lock), F2, F3, 2E, 36, 3E, 26, 64, 65, 66 and 67 are prefixes wherever they fall before the opcode. The first byte that is not one of these is the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_vld | input | 1 | A stream byte is present this cycle |
| byte_data | input | 8 | Stream byte |
| byte_first | input | 1 | This byte starts an instruction |
| byte_last | input | 1 | This byte ends the instruction |
| res_vld | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 0 legal, 1 length fault, 2 lock fault |
| res_vector | output | 8 | Exception vector: 0, 13 or 6 |

## Verification
The hardest case to reach is the collision of both faults on one byte. This happens when a locked instruction that is not permitted delivers its end flag on exactly the 16th byte. The stimulus pads a lock prefix with fourteen redundant operand-size prefixes so that the bad opcode lands on byte 16. A second sequence stops one byte short, at 15 bytes, to pin the boundary. A scoreboard queue also catches any extra strobe, so the bytes sent after a length fault, the stray bytes sent while idle and the instruction abandoned by a new start flag all show up if they produce a result.

// File: rtl/insn_guard_pkg.sv
// Package: shared types and constants for the instruction validator.
// Assumes: vector numbers fixed by the architecture being checked.
package insn_guard_pkg;
    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_LEN  = 2'd1,
        RES_LOCK = 2'd2
    } res_kind_e;

    typedef enum logic [2:0] {
        LK_NONE,
        LK_ANY,
        LK_REG0TO6,
        LK_REG01,
        LK_REG23,
        LK_REG567
    } lock_cls_e;

    typedef enum logic [2:0] {
        PH_PREFIX,
        PH_OPC2,
        PH_MODRM,
        PH_TAIL
    } phase_e;

    localparam logic [7:0] VEC_NONE = 8'd0;
    localparam logic [7:0] VEC_LEN  = 8'd13;
    localparam logic [7:0] VEC_LOCK = 8'd6;
    localparam logic [7:0] ESC_BYTE = 8'h0F;
endpackage

// File: rtl/ig_prefix_detect.sv
// Module: ig_prefix_detect
// Classifies one byte as a prefix and flags the bus-lock prefix.
// Assumes: only called while the instruction is still in its prefix phase.
module ig_prefix_detect (
    input  logic [7:0] byte_in,
    output logic       is_prefix,
    output logic       is_lock
);
    // Match against the recognised prefix set.
    always_comb begin
        is_lock = (byte_in == 8'hF0);
        unique case (byte_in)
            8'hF0, 8'hF2, 8'hF3,
            8'h2E, 8'h36, 8'h3E, 8'h26,
            8'h64, 8'h65, 8'h66, 8'h67: is_prefix = 1'b1;
            default:                    is_prefix = 1'b0;
        endcase
    end
endmodule

// File: rtl/ig_lock_class.sv
// Module: ig_lock_class
// Maps an opcode byte to the reg-field class under which locking is allowed.
// Assumes: two_byte is set when the byte follows the 0F escape.
module ig_lock_class
    import insn_guard_pkg::*;
(
    input  logic [7:0] opc,
    input  logic       two_byte,
    output lock_cls_e  cls
);
    // Whitelist lookup for one- and two-byte opcode maps.
    always_comb begin
        cls = LK_NONE;
        if (two_byte) begin
            if (opc == 8'hAB || opc == 8'hB3 || opc == 8'hBB) cls = LK_ANY;
            else if (opc == 8'hBA)                            cls = LK_REG567;
        end else begin
            if (opc[7:6] == 2'b00 && opc[2:1] == 2'b00 && opc[5:3] != 3'd7)
                cls = LK_ANY;
            else if (opc == 8'h86 || opc == 8'h87)
                cls = LK_ANY;
            else if (opc[7:2] == 6'b100000)
                cls = LK_REG0TO6;
            else if (opc == 8'hFE || opc == 8'hFF)
                cls = LK_REG01;
            else if (opc == 8'hF6 || opc == 8'hF7)
                cls = LK_REG23;
        end
    end
endmodule

// File: rtl/ig_modrm_check.sv
// Module: ig_modrm_check
// Decides whether an addressing byte makes a locked opcode legal.
// Assumes: cls came from ig_lock_class for the same instruction.
module ig_modrm_check
    import insn_guard_pkg::*;
(
    input  lock_cls_e  cls,
    input  logic [7:0] modrm,
    output logic       lock_ok
);
    logic       mem_dst;
    logic [2:0] reg_f;

    // Memory destination plus reg-field match for the class.
    always_comb begin
        mem_dst = (modrm[7:6] != 2'b11);
        reg_f   = modrm[5:3];
        unique case (cls)
            LK_ANY:     lock_ok = mem_dst;
            LK_REG0TO6: lock_ok = mem_dst && (reg_f != 3'd7);
            LK_REG01:   lock_ok = mem_dst && (reg_f <= 3'd1);
            LK_REG23:   lock_ok = mem_dst && (reg_f == 3'd2 || reg_f == 3'd3);
            LK_REG567:  lock_ok = mem_dst && (reg_f >= 3'd5);
            default:    lock_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ig_len_counter.sv
// Module: ig_len_counter
// Counts accepted bytes of the open instruction and flags the ceiling breach.
// Assumes: the owner stops feeding bytes after over_next is seen.
module ig_len_counter #(
    parameter int MAX_LEN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic restart,
    output logic over_next
);
    localparam int CW = $clog2(MAX_LEN + 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_next;

    // Length this byte gives the instruction.
    always_comb begin
        len_next  = restart ? CW'(1) : cnt_q + CW'(1);
        over_next = (len_next > CW'(MAX_LEN));
    end

    // Hold the count, never storing a value past the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (take && !over_next) cnt_q <= len_next;
    end

    AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_LEN)); // R3
endmodule

// File: rtl/insn_guard.sv
// Module: insn_guard (top)
// Walks the byte stream of each instruction through prefix, opcode and
// addressing-byte phases and emits one result per instruction.
// Assumes: upstream marks first and last bytes; last may be absent on faults.
module insn_guard
    import insn_guard_pkg::*;
#(
    parameter int MAX_LEN = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       byte_first,
    input  logic       byte_last,
    output logic       res_vld,
    output logic [1:0] res_kind,
    output logic [7:0] res_vector
);
    logic      active_q;
    phase_e    phase_q, ph_cur, ph_n;
    logic      lock_q, lock_cur, lock_n;
    lock_cls_e cls_q, cls_cur, cls_n, cls_lut;
    logic      okq, ok_cur, ok_n, ok_lut;
    logic      take, is_prefix, is_lock, over;
    res_kind_e kind_q;

    assign take = byte_vld && (byte_first || active_q);

    ig_prefix_detect u_pfx (
        .byte_in   (byte_data),
        .is_prefix (is_prefix),
        .is_lock   (is_lock)
    );

    ig_lock_class u_cls (
        .opc      (byte_data),
        .two_byte (ph_cur == PH_OPC2),
        .cls      (cls_lut)
    );

    ig_modrm_check u_mrm (
        .cls     (cls_cur),
        .modrm   (byte_data),
        .lock_ok (ok_lut)
    );

    ig_len_counter #(.MAX_LEN(MAX_LEN)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .restart   (byte_first),
        .over_next (over)
    );

    // Start-of-instruction view: a start flag replaces the stored context.
    always_comb begin
        ph_cur   = byte_first ? PH_PREFIX : phase_q;
        lock_cur = byte_first ? 1'b0      : lock_q;
        cls_cur  = byte_first ? LK_NONE   : cls_q;
        ok_cur   = byte_first ? 1'b0      : okq;
    end

    // Phase walk for the current byte.
    always_comb begin
        ph_n   = ph_cur;
        lock_n = lock_cur;
        cls_n  = cls_cur;
        ok_n   = ok_cur;
        unique case (ph_cur)
            PH_PREFIX: begin
                if (is_prefix) begin
                    lock_n = lock_cur | is_lock;
                end else if (byte_data == ESC_BYTE) begin
                    ph_n = PH_OPC2;
                end else begin
                    cls_n = cls_lut;
                    ph_n  = (cls_lut != LK_NONE) ? PH_MODRM : PH_TAIL;
                end
            end
            PH_OPC2: begin
                cls_n = cls_lut;
                ph_n  = (cls_lut != LK_NONE) ? PH_MODRM : PH_TAIL;
            end
            PH_MODRM: begin
                ok_n = ok_lut;
                ph_n = PH_TAIL;
            end
            default: ph_n = PH_TAIL;
        endcase
    end

    // Context registers and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= PH_PREFIX;
            lock_q   <= 1'b0;
            cls_q    <= LK_NONE;
            okq      <= 1'b0;
            res_vld  <= 1'b0;
            kind_q   <= RES_OK;
            res_vector <= VEC_NONE;
        end else begin
            res_vld <= 1'b0;
            if (take) begin
                phase_q <= ph_n;
                lock_q  <= lock_n;
                cls_q   <= cls_n;
                okq     <= ok_n;
                if (over) begin
                    active_q   <= 1'b0;
                    res_vld    <= 1'b1;
                    kind_q     <= RES_LEN;
                    res_vector <= VEC_LEN;
                end else if (byte_last) begin
                    active_q <= 1'b0;
                    res_vld  <= 1'b1;
                    if (lock_n && !ok_n) begin
                        kind_q     <= RES_LOCK;
                        res_vector <= VEC_LOCK;
                    end else begin
                        kind_q     <= RES_OK;
                        res_vector <= VEC_NONE;
                    end
                end else begin
                    active_q <= 1'b1;
                end
            end
        end
    end

    assign res_kind = kind_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !res_vld); // R1
    AST_STROBE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> !res_vld); // R10
    AST_OK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind == 2'd0) |-> res_vector == 8'd0); // R2
    AST_LEN_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind == 2'd1) |-> res_vector == 8'd13); // R3
    AST_LOCK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind == 2'd2) |-> res_vector == 8'd6); // R6
    AST_KIND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> res_kind != 2'd3); // R2
    AST_NO_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !byte_first) |=> !res_vld); // R4
endmodule

// File: tb/insn_guard_tb.sv
// Bench: scoreboard for insn_guard. Driver tasks queue expected results,
// a monitor pops and compares each strobe.
module insn_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_first = 1'b0;
    logic       byte_last = 1'b0;
    logic       res_vld;
    logic [1:0] res_kind;
    logic [7:0] res_vector;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [7:0] ins [0:19];

    logic [1:0] q_kind [$];
    logic [7:0] q_vec  [$];
    string      q_tag  [$];

    always #5 clk = ~clk;

    insn_guard u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .byte_first (byte_first),
        .byte_last  (byte_last),
        .res_vld    (res_vld),
        .res_kind   (res_kind),
        .res_vector (res_vector)
    );

    // Monitor: compare every strobe with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            checks++;
            if (q_kind.size() == 0) begin
                fails++;
                $display("FAIL R4/R10 unexpected strobe: actual kind=%0d vec=%0d, expected none",
                         res_kind, res_vector);
            end else begin
                logic [1:0] ek;
                logic [7:0] ev;
                string      et;
                ek = q_kind.pop_front();
                ev = q_vec.pop_front();
                et = q_tag.pop_front();
                if (res_kind !== ek || res_vector !== ev) begin
                    fails++;
                    $display("FAIL %s: actual kind=%0d vec=%0d, expected kind=%0d vec=%0d",
                             et, res_kind, res_vector, ek, ev);
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld = 1'b0; byte_first = 1'b0; byte_last = 1'b0;
        end
    endtask

    // Drive ins[0..n-1]; the end flag goes on byte 'endpos' (-1 for none).
    task automatic send(input int n, input int endpos, input bit expect_res,
                        input logic [1:0] k, input logic [7:0] v, input string tag);
        if (expect_res) begin
            q_kind.push_back(k); q_vec.push_back(v); q_tag.push_back(tag);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld   = 1'b1;
            byte_data  = ins[i];
            byte_first = (i == 0);
            byte_last  = (i == endpos);
        end
        idle(2);
    endtask

    task automatic ld4(input int n, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] c, input logic [7:0] d);
        ins[0] = a; ins[1] = b; ins[2] = c; ins[3] = d;
        if (n < 4) ins[3] = 8'h00;
    endtask

    initial begin
        // R1: quiet during and just after reset
        repeat (3) @(negedge clk);
        checks++;
        if (res_vld !== 1'b0) begin
            fails++; $display("FAIL R1 in reset: actual %0b expected 0", res_vld);
        end
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_vld !== 1'b0) begin
            fails++; $display("FAIL R1 after reset: actual %0b expected 0", res_vld);
        end

        // R2: plain instructions
        ld4(1, 8'h90, 0, 0, 0);       send(1, 0, 1, 2'd0, 8'd0, "R2 one byte");
        ld4(3, 8'h8B, 8'h45, 8'h08, 0); send(3, 2, 1, 2'd0, 8'd0, "R2 three bytes");

        // R3: 15 bytes legal, 16 faults before end
        for (int i = 0; i < 14; i++) ins[i] = 8'h66;
        ins[14] = 8'h90;
        send(15, 14, 1, 2'd0, 8'd0, "R3 fifteen bytes legal");
        for (int i = 0; i < 16; i++) ins[i] = 8'h66;
        ins[16] = 8'h90; ins[17] = 8'h90;
        send(18, 17, 1, 2'd1, 8'd13, "R3 sixteenth byte / R4 tail ignored");

        // R5: lockable memory forms
        ld4(3, 8'hF0, 8'h01, 8'h08, 0); send(3, 2, 1, 2'd0, 8'd0, "R5 lock 01 mem");
        ld4(3, 8'hF0, 8'h87, 8'h06, 0); send(3, 2, 1, 2'd0, 8'd0, "R5 lock 87 mem");
        ld4(3, 8'hF0, 8'hFE, 8'h08, 0); send(3, 2, 1, 2'd0, 8'd0, "R5 lock FE /1");
        ld4(3, 8'hF0, 8'hF6, 8'h10, 0); send(3, 2, 1, 2'd0, 8'd0, "R5 lock F6 /2");
        ld4(4, 8'hF0, 8'h83, 8'h30, 8'h01); send(4, 3, 1, 2'd0, 8'd0, "R5 lock 83 /6");

        // R6: lock on opcode outside the whitelist
        ld4(3, 8'hF0, 8'h89, 8'h08, 0); send(3, 2, 1, 2'd2, 8'd6, "R6 lock 89");
        ld4(3, 8'hF0, 8'h38, 8'h08, 0); send(3, 2, 1, 2'd2, 8'd6, "R6 lock 38");
        ld4(1, 8'hF0, 0, 0, 0);        send(1, 0, 1, 2'd2, 8'd6, "R6 lock alone");

        // R7: register form or disallowed reg field
        ld4(3, 8'hF0, 8'h01, 8'hC0, 0); send(3, 2, 1, 2'd2, 8'd6, "R7 mod 3");
        ld4(3, 8'hF0, 8'hFE, 8'h10, 0); send(3, 2, 1, 2'd2, 8'd6, "R7 FE /2");
        ld4(3, 8'hF0, 8'hF6, 8'h00, 0); send(3, 2, 1, 2'd2, 8'd6, "R7 F6 /0");
        ld4(4, 8'hF0, 8'h80, 8'h38, 8'h01); send(4, 3, 1, 2'd2, 8'd6, "R7 80 /7");

        // R8: escape map
        ld4(4, 8'hF0, 8'h0F, 8'hAB, 8'h08); send(4, 3, 1, 2'd0, 8'd0, "R8 0F AB");
        ins[4] = 8'h05;
        ld4(4, 8'hF0, 8'h0F, 8'hBA, 8'h28); ins[4] = 8'h05;
        send(5, 4, 1, 2'd0, 8'd0, "R8 0F BA /5");
        ld4(4, 8'hF0, 8'h0F, 8'hBA, 8'h20); ins[4] = 8'h05;
        send(5, 4, 1, 2'd2, 8'd6, "R8 0F BA /4");
        ld4(4, 8'hF0, 8'h0F, 8'hA3, 8'h08); send(4, 3, 1, 2'd2, 8'd6, "R8 0F A3");

        // R9: both faults on byte 16 -> length wins
        ins[0] = 8'hF0;
        for (int i = 1; i < 15; i++) ins[i] = 8'h66;
        ins[15] = 8'h89;
        send(16, 15, 1, 2'd1, 8'd13, "R9 length over lock");

        // R10: abandoned instruction, then stray bytes while idle
        ld4(2, 8'hF0, 8'h01, 0, 0);   send(2, -1, 0, 2'd0, 8'd0, "R10");
        ld4(1, 8'h90, 0, 0, 0);       send(1, 0, 1, 2'd0, 8'd0, "R10 restart");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_vld = 1'b1; byte_data = 8'h90; byte_first = 1'b0; byte_last = 1'b1;
        end
        idle(3);

        // R11: lock first, then every other prefix, then a lockable op
        ins[0] = 8'hF0; ins[1] = 8'h2E; ins[2] = 8'h36; ins[3] = 8'h3E;
        ins[4] = 8'h26; ins[5] = 8'h64; ins[6] = 8'h65; ins[7] = 8'h66;
        ins[8] = 8'h67; ins[9] = 8'hF2; ins[10] = 8'hF3; ins[11] = 8'h09;
        ins[12] = 8'h08;
        send(13, 12, 1, 2'd0, 8'd0, "R11 all prefixes");

        idle(5);
        checks++;
        if (q_kind.size() != 0) begin
            fails++;
            $display("FAIL R4 missing strobes: actual %0d pending, expected 0", q_kind.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule